// File: doc/BRIEF.md
# Cartridge PRG/CHR Bank Mapper

This block turns the CPU and PPU address buses of an 8-bit console cartridge into widened program-ROM and character-ROM addresses. Software programs it through two write ports in the 8000-FFFF window. An even address stores a 3-bit index that names one of eight bank registers. An odd address loads a 6-bit value into the register the index names.

Program ROM is split into four 8 KB windows. The two lower windows are switchable and the two upper windows are tied to the last two banks of a 128 KB image. Character ROM (64 KB at most) is seen through a fixed layout. The lower pattern table uses two 2 KB banks and the upper pattern table uses four 1 KB banks.

The nametable RAM A10 line comes from one of two sources. It can follow a strapped horizontal or vertical arrangement. When the alternate source is strapped, it follows the top bit of the 2 KB character bank that the nametable address would pick in the lower pattern table.

Top module: `bank_mapper`

## Requirements
- R1: After reset the index and all eight bank registers are zero, so every CHR window maps to bank 0, the two switchable PRG windows map to bank 0, and C000-DFFF and E000-FFFF map to banks 14 and 15 with no write needed.
- R2: A cycle with `cpu_wr` high, `cpu_addr[15]` = 1 and `cpu_addr[0]` = 0 stores `cpu_data[2:0]` as the index. Data bits 7:3 and address bits 14:1 have no effect.
- R3: A cycle with `cpu_wr` high, `cpu_addr[15]` = 1 and `cpu_addr[0]` = 1 stores `cpu_data[5:0]` into the register the index names. Cycles with `cpu_wr` low or `cpu_addr[15]` = 0 change no register.
- R4: CPU 8000-9FFF (`cpu_addr[14:13]` = 0) uses bits 3:0 of register 6 as the PRG bank. A000-BFFF (`cpu_addr[14:13]` = 1) uses bits 3:0 of register 7.
- R5: CPU C000-DFFF always selects PRG bank 14 and E000-FFFF always selects bank 15. `prg_addr` = bank × 8192 + `cpu_addr[12:0]`.
- R6: PPU 0000-07FF uses register 0 and 0800-0FFF uses register 1. Bit 0 of the register is replaced by `ppu_addr[10]`, so the 1 KB bank is (reg with bit 0 cleared) + `ppu_addr[10]`.
- R7: PPU 1000, 1400, 1800 and 1C00 (`ppu_addr[12:10]` = 4..7) use registers 2, 3, 4 and 5 as 1 KB banks. `chr_addr` = bank × 1024 + `ppu_addr[9:0]`.
- R8: The outputs are combinational. A change of `cpu_addr` or `ppu_addr` shows on `prg_addr`/`chr_addr` in the same cycle. A register write shows after the clock edge that takes it.
- R9: With `nt_src_chr` = 0, `nt_a10` equals `ppu_addr[10]` when `mirror_vert` = 1 and `ppu_addr[11]` when `mirror_vert` = 0.
- R10: With `nt_src_chr` = 1, `nt_a10` equals bit 5 of register 0 when `ppu_addr[11]` = 0 and bit 5 of register 1 when `ppu_addr[11]` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | PPU address |
| nt_src_chr | input | 1 | Strap: 1 takes nametable A10 from the CHR bank top bit |
| mirror_vert | input | 1 | Strap: 1 vertical, 0 horizontal when `nt_src_chr` = 0 |
| prg_addr | output | 17 | Program-ROM byte address |
| chr_addr | output | 16 | Character-ROM byte address |
| nt_a10 | output | 1 | Nametable RAM A10 |

## Verification
The assertions assume the straps `nt_src_chr` and `mirror_vert` are steady. They also assume `cpu_wr`, `cpu_addr` and `cpu_data` settle before the rising edge, because the write ports sample them there. The bench changes every input on the falling edge and holds the straps constant inside each test step. It samples the combinational outputs one time unit after it drives the addresses.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int NREG       = 8;
  localparam int IDX_W      = $clog2(NREG);
  localparam int REG_W      = 6;
  localparam int PRG_BANK_W = 4;
  localparam int CHR_BANK_W = REG_W;
  localparam int PRG_OFF_W  = 13;
  localparam int CHR_OFF_W  = 10;
  localparam int PRG_ADDR_W = PRG_BANK_W + PRG_OFF_W;
  localparam int CHR_ADDR_W = CHR_BANK_W + CHR_OFF_W;

  typedef logic [REG_W-1:0] bank_reg_t;

  // PRG bank for one of the four 8 KB CPU windows
  function automatic logic [PRG_BANK_W-1:0] prg_bank_f(
      input logic [1:0] slot, input bank_reg_t r_lo, input bank_reg_t r_hi);
    logic [PRG_BANK_W-1:0] b;
    case (slot)
      2'd0:    b = r_lo[PRG_BANK_W-1:0];
      2'd1:    b = r_hi[PRG_BANK_W-1:0];
      2'd2:    b = {{(PRG_BANK_W-1){1'b1}}, 1'b0};
      default: b = '1;
    endcase
    return b;
  endfunction

  // CHR 1 KB bank for one of eight PPU windows
  function automatic logic [CHR_BANK_W-1:0] chr_bank_f(
      input logic [2:0] slot, input logic [NREG-1:0][REG_W-1:0] regs);
    logic [CHR_BANK_W-1:0] b;
    case (slot)
      3'd0, 3'd1: b = {regs[0][REG_W-1:1], slot[0]};
      3'd2, 3'd3: b = {regs[1][REG_W-1:1], slot[0]};
      3'd4:       b = regs[2];
      3'd5:       b = regs[3];
      3'd6:       b = regs[4];
      default:    b = regs[5];
    endcase
    return b;
  endfunction

  // Nametable A10 source selection
  function automatic logic nt_a10_f(
      input logic from_chr, input logic vert, input logic a11, input logic a10,
      input bank_reg_t r0, input bank_reg_t r1);
    logic v;
    if (from_chr) v = a11 ? r1[REG_W-1] : r0[REG_W-1];
    else          v = vert ? a10 : a11;
    return v;
  endfunction
endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
  import mapper_pkg::*;
#(
  parameter int N   = NREG,
  parameter int W   = REG_W,
  parameter int IW  = IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_a15,
  input  logic              cpu_a0,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] regs_o
);
  logic [IW-1:0]       idx_q;
  logic [N-1:0][W-1:0] regs_q;
  logic                sel_wr;
  logic                dat_wr;

  assign sel_wr = cpu_wr & cpu_a15 & ~cpu_a0;
  assign dat_wr = cpu_wr & cpu_a15 &  cpu_a0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (sel_wr) idx_q <= wdata[IW-1:0];
  end

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= '0;
      else if (dat_wr && (idx_q == IW'(i))) regs_q[i] <= wdata;
    end
  end

  assign regs_o = regs_q;

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> idx_q == $past(wdata[IW-1:0]));
  // R3
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> regs_q[$past(idx_q)] == $past(wdata));
  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(regs_q));
  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(idx_q));
endmodule

// File: rtl/mapper_prg.sv
module mapper_prg
  import mapper_pkg::*;
#(
  parameter int BW = PRG_BANK_W,
  parameter int OW = PRG_OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OW+1:0]   cpu_off,
  input  bank_reg_t       r_lo,
  input  bank_reg_t       r_hi,
  output logic [BW+OW-1:0] prg_addr
);
  logic [1:0]    win;
  logic [BW-1:0] bank;
  logic          fixed_win;

  assign win       = cpu_off[OW+1:OW];
  assign fixed_win = win[1];
  assign bank      = prg_bank_f(win, r_lo, r_hi);
  assign prg_addr  = {bank, cpu_off[OW-1:0]};

  // R5
  fixed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_win |-> (&prg_addr[BW+OW-1:OW+1]) && (prg_addr[OW] == cpu_off[OW]));
  // R4
  switch_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win == 2'd1) |-> prg_addr[BW+OW-1:OW] == r_hi[BW-1:0]);
endmodule

// File: rtl/mapper_chr.sv
module mapper_chr
  import mapper_pkg::*;
#(
  parameter int N  = NREG,
  parameter int W  = REG_W,
  parameter int OW = CHR_OFF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OW+2:0]       ppu_off,
  input  logic [N-1:0][W-1:0] regs,
  input  logic                nt_src_chr,
  input  logic                mirror_vert,
  output logic [W+OW-1:0]     chr_addr,
  output logic                nt_a10
);
  logic [2:0]   win;
  logic [W-1:0] bank;
  logic         low_table;

  assign win       = ppu_off[OW+2:OW];
  assign low_table = ~win[2];
  assign bank      = chr_bank_f(win, regs);
  assign chr_addr  = {bank, ppu_off[OW-1:0]};
  assign nt_a10    = nt_a10_f(nt_src_chr, mirror_vert, ppu_off[OW+1],
                              ppu_off[OW], regs[0], regs[1]);

  // R6
  half_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_table |-> chr_addr[OW] == ppu_off[OW]);
  // R9
  vert_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nt_src_chr && mirror_vert) |-> nt_a10 == ppu_off[OW]);
  // R10
  chr_nt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_src_chr && !ppu_off[OW+1]) |-> nt_a10 == regs[0][W-1]);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import mapper_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_wr,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_data,
  input  logic [13:0]           ppu_addr,
  input  logic                  nt_src_chr,
  input  logic                  mirror_vert,
  output logic [PRG_ADDR_W-1:0] prg_addr,
  output logic [CHR_ADDR_W-1:0] chr_addr,
  output logic                  nt_a10
);
  logic [NREG-1:0][REG_W-1:0] regs;
  logic unused_bits;

  assign unused_bits = ^{cpu_data[7:REG_W], ppu_addr[13]};

  mapper_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr),
    .cpu_a15(cpu_addr[15]), .cpu_a0(cpu_addr[0]),
    .wdata(cpu_data[REG_W-1:0]), .regs_o(regs)
  );

  mapper_prg u_prg (
    .clk(clk), .rst_n(rst_n), .cpu_off(cpu_addr[PRG_OFF_W+1:0]),
    .r_lo(regs[6]), .r_hi(regs[7]), .prg_addr(prg_addr)
  );

  mapper_chr u_chr (
    .clk(clk), .rst_n(rst_n), .ppu_off(ppu_addr[CHR_OFF_W+2:0]),
    .regs(regs), .nt_src_chr(nt_src_chr), .mirror_vert(mirror_vert),
    .chr_addr(chr_addr), .nt_a10(nt_a10)
  );
endmodule

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_wr = 0;
  logic [15:0] cpu_addr = 16'h8000;
  logic [7:0]  cpu_data = 0;
  logic [13:0] ppu_addr = 0;
  logic        nt_src_chr = 0;
  logic        mirror_vert = 0;
  logic [16:0] prg_addr;
  logic [15:0] chr_addr;
  logic        nt_a10;

  int checks = 0;
  int errors = 0;
  int m [8];

  always #5 clk = ~clk;

  bank_mapper uut (.*);

  localparam int NV = 10;
  localparam logic [15:0] VADR [NV] = '{16'h8000, 16'hC002, 16'h8004, 16'hFFFE, 16'h8006,
                                        16'hA008, 16'h800A, 16'hE00C, 16'h800E, 16'h8000};
  localparam logic [7:0]  VSEL [NV] = '{8'hF8, 8'h01, 8'hAA, 8'h03, 8'h04,
                                        8'h0D, 8'hF6, 8'h07, 8'h06, 8'h01};
  localparam logic [7:0]  VDAT [NV] = '{8'h2B, 8'hC7, 8'h15, 8'h3F, 8'h20,
                                        8'h09, 8'hFA, 8'h4B, 8'h03, 8'h3E};

  function automatic int exp_prg(input int a);
    int slot = (a - 32768) / 8192;
    int bank;
    if (slot == 2) bank = 14;
    else if (slot == 3) bank = 15;
    else bank = m[6 + slot] % 16;
    return bank * 8192 + a % 8192;
  endfunction

  function automatic int exp_chr(input int pa);
    int bank;
    if (pa < 4096) bank = (m[pa / 2048] / 2) * 2 + (pa / 1024) % 2;
    else bank = m[2 + (pa - 4096) / 1024];
    return bank * 1024 + pa % 1024;
  endfunction

  function automatic int exp_nt(input int pa);
    if (nt_src_chr) return (m[(pa / 2048) % 2] / 32) % 2;
    return mirror_vert ? (pa / 1024) % 2 : (pa / 2048) % 2;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic check_prg(input int a, input string tag);
    cpu_addr = 16'(a);
    #1 chk(tag, int'(prg_addr), exp_prg(a));
  endtask

  task automatic check_chr(input int pa, input string tag);
    ppu_addr = 14'(pa);
    #1 chk(tag, int'(chr_addr), exp_chr(pa));
  endtask

  task automatic check_all();
    for (int s = 0; s < 4; s++)
      check_prg(32768 + s * 8192 + 291 * (s + 1), s < 2 ? "R4" : "R5");
    for (int s = 0; s < 8; s++)
      check_chr(s * 1024 + 77 * (s + 3), s < 4 ? "R6" : "R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_all();

    // vector table: select then data, with masking of upper bits (R2, R3)
    for (int v = 0; v < NV; v++) begin
      cpu_write(VADR[v], VSEL[v]);
      cpu_write(VADR[v] | 16'h0001, VDAT[v]);
      m[VSEL[v] % 8] = VDAT[v] % 64;
      check_all();
    end

    // R3 writes with a15 low or strobe low are ignored
    cpu_write(16'h8000, 8'h02);
    cpu_write(16'h0001, 8'h11);
    @(negedge clk);
    cpu_addr = 16'h8001; cpu_data = 8'h22; cpu_wr = 0;
    @(negedge clk);
    check_chr(16'h1000, "R3");
    // R2 select write with a15 low ignored: index stays 2
    cpu_write(16'h7FFE, 8'h05);
    cpu_write(16'h9001, 8'h19);
    m[2] = 25;
    check_chr(16'h1005, "R2");
    check_chr(16'h1C05, "R2");

    // R8 combinational: output follows address same cycle, offsets pass through
    check_prg(16'h9FFF, "R8");
    check_prg(16'hB000, "R8");
    check_chr(16'h03FF, "R8");
    check_chr(16'h1BFF, "R8");

    // R9 hardwired mirroring
    nt_src_chr = 0;
    for (int k = 0; k < 4; k++) begin
      mirror_vert = k[0];
      ppu_addr = 14'(16'h2000 + (k / 2) * 16'h0C00 + 16'h0400 * k[0]);
      #1 chk("R9", int'(nt_a10), exp_nt(int'(ppu_addr)));
    end
    // R10 nametable A10 from CHR bank top bit
    nt_src_chr = 1;
    cpu_write(16'h8000, 8'h00); cpu_write(16'h8001, 8'h20); m[0] = 32;
    cpu_write(16'h8000, 8'h01); cpu_write(16'h8001, 8'h1F); m[1] = 31;
    for (int k = 0; k < 4; k++) begin
      ppu_addr = 14'(16'h2000 + k * 16'h0400);
      #1 chk("R10", int'(nt_a10), exp_nt(int'(ppu_addr)));
    end
    cpu_write(16'h8000, 8'h01); cpu_write(16'h8001, 8'h3F); m[1] = 63;
    ppu_addr = 14'h2C00;
    #1 chk("R10", int'(nt_a10), 1);
    nt_src_chr = 0;

    // R1 reset again clears everything
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) m[i] = 0;
    check_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule